// File: doc/BRIEF.md
# Access Stall Controller

This block decides when the CPU-side request port of a cache has to hold off new requests. Any of four independent stall causes can be raised or dropped, one strobe at a time. Each cause owns one bit of a shared mask, and the port stays closed for as long as any bit is set. A requester that was turned away while the port was closed gets a retry once the port opens again.

The block also keeps statistics for each stall episode. An episode begins when the first cause arrives on an empty mask and ends when the last cause leaves it. Only the cause that begins an episode has its episode count raised. Only the cause whose clear empties the mask is charged the cycles the episode lasted. The queues that raise and drop the causes sit outside this block.

Top module: `access_stall_ctrl`

## Requirements
- R1: After reset, `portBlocked` and `retryPulse` are low and every episode and cycle counter reads zero.
- R2: Cause index k maps to mask bit k. The causes are 0 for no free miss entry, 1 for no free write-buffer entry, 2 for no free target slot and 3 for a pending write-invalidate. A set strobe ORs the bit in and a clear strobe ANDs it out. `portBlocked` is high in the cycle after any bit is set, for as long as the mask is non-zero. Clearing a bit that is not set changes nothing.
- R3: A set strobe that lands on an empty mask starts an episode. It raises `portBlocked` and adds one to that cause's episode counter, both visible in the next cycle.
- R4: A set strobe that lands on a non-zero mask only adds its bit. No counter changes.
- R5: A clear strobe that empties the mask ends the episode. `portBlocked` drops in the next cycle, and the clearing cause's cycle counter grows by the number of cycles `portBlocked` was high in that episode.
- R6: When a set and a clear of the same cause arrive in the same cycle, the set wins and the bit ends up set.
- R7: If `reqValid` is seen while `portBlocked` is high, `retryPulse` is high for exactly one cycle, starting one cycle after `portBlocked` falls. A request made while the port is open produces no retry.
- R8: Episode counters are EPI_W bits wide and hold at their all-ones value instead of wrapping.
- R9: Cycle counters are CYC_W bits wide and hold at their all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setValid | input | 1 | Raise the cause given on setCause |
| setCause | input | 2 | Index of the cause to raise |
| clrValid | input | 1 | Drop the cause given on clrCause |
| clrCause | input | 2 | Index of the cause to drop |
| reqValid | input | 1 | A CPU-side request is being offered |
| portBlocked | output | 1 | Port refuses new requests |
| retryPulse | output | 1 | One-cycle retry to a requester that was turned away |
| episodeFlat | output | 4*EPI_W | Episode counters, cause k in bits k*EPI_W upward |
| cyclesFlat | output | 4*CYC_W | Blocked-cycle counters, cause k in bits k*CYC_W upward |

## Verification
The bench builds the block with EPI_W = 4 and CYC_W = 6, so the counters saturate at 15 episodes and 63 cycles. That puts the saturation cases of R8 and R9 within a few dozen cycles of stimulus, instead of the tens of thousands of episodes and billions of cycles the default widths would need. With the narrow counters the bench can drive twenty episodes on one cause, and a single stall of more than seventy cycles followed by a second stall, and check that both counters hold at all-ones.

// File: rtl/access_stall_pkg.sv
package access_stall_pkg;
  localparam int CAUSE_COUNT = 4;
  localparam int CAUSE_IDX_W = $clog2(CAUSE_COUNT);

  typedef logic [CAUSE_IDX_W-1:0] cause_idx_t;

  // bit position of each cause in the stall mask equals its value
  typedef enum logic [CAUSE_IDX_W-1:0] {
    CAUSE_MISS_FULL = 2'd0,
    CAUSE_WBUF_FULL = 2'd1,
    CAUSE_TGT_FULL  = 2'd2,
    CAUSE_WINV_PEND = 2'd3
  } stall_cause_e;

  // strobes from the mask control to the statistics datapath
  typedef struct packed {
    logic       startEp;
    logic       endEp;
    logic       holding;
    cause_idx_t startIdx;
    cause_idx_t endIdx;
  } stat_strobe_t;
endpackage

// File: rtl/access_stall_control.sv
module access_stall_control
  import access_stall_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         setValid,
  input  cause_idx_t   setCause,
  input  logic         clrValid,
  input  cause_idx_t   clrCause,
  input  logic         reqValid,
  output logic         portBlocked,
  output logic         retryPulse,
  output stat_strobe_t strobe
);
  logic [CAUSE_COUNT-1:0] maskQ, maskD, setBits, clrBits;
  logic pendQ, pendD, issueRetry, retryQ;

  always_comb begin
    setBits = '0;
    clrBits = '0;
    if (setValid) setBits[setCause] = 1'b1;
    if (clrValid) clrBits[clrCause] = 1'b1;
    // the set is applied after the clear, so it wins on a shared cause
    maskD = (maskQ & ~clrBits) | setBits;
  end

  assign portBlocked = |maskQ;

  always_comb begin
    strobe.startEp  = (maskQ == '0) && (maskD != '0);
    strobe.endEp    = (maskQ != '0) && (maskD == '0);
    strobe.holding  = (maskQ != '0);
    strobe.startIdx = setCause;
    strobe.endIdx   = clrCause;
  end

  // a retry owed to a turned-away requester goes out once the port is open
  assign issueRetry = pendQ && !portBlocked;

  always_comb begin
    if (issueRetry) pendD = 1'b0;
    else            pendD = pendQ | (reqValid & portBlocked);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ  <= '0;
      pendQ  <= 1'b0;
      retryQ <= 1'b0;
    end else begin
      maskQ  <= maskD;
      pendQ  <= pendD;
      retryQ <= issueRetry;
    end
  end

  assign retryPulse = retryQ;
endmodule

// File: rtl/access_stall_datapath.sv
module access_stall_datapath
  import access_stall_pkg::*;
#(
  parameter int EPI_W = 16,
  parameter int CYC_W = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  stat_strobe_t                 strobe,
  output logic [CAUSE_COUNT*EPI_W-1:0] episodeFlat,
  output logic [CAUSE_COUNT*CYC_W-1:0] cyclesFlat
);
  localparam logic [EPI_W-1:0] EPI_MAX = '1;
  localparam logic [CYC_W-1:0] CYC_MAX = '1;
  localparam logic [CYC_W-1:0] CYC_ONE = CYC_W'(1);

  // length of the running episode, counting the cycles the port was closed
  logic [CYC_W-1:0] durQ;

  always_ff @(posedge clk) begin
    if (!rstN)                               durQ <= '0;
    else if (strobe.startEp)                 durQ <= CYC_ONE;
    else if (strobe.holding && durQ != CYC_MAX) durQ <= durQ + CYC_ONE;
  end

  for (genvar g = 0; g < CAUSE_COUNT; g++) begin : g_cause
    logic [EPI_W-1:0] epiQ;
    logic [CYC_W-1:0] cycQ;
    logic [CYC_W:0]   cycSum;
    logic             hitStart, hitEnd;

    assign hitStart = strobe.startEp && (strobe.startIdx == CAUSE_IDX_W'(g));
    assign hitEnd   = strobe.endEp   && (strobe.endIdx   == CAUSE_IDX_W'(g));
    assign cycSum   = {1'b0, cycQ} + {1'b0, durQ};

    always_ff @(posedge clk) begin
      if (!rstN) begin
        epiQ <= '0;
        cycQ <= '0;
      end else begin
        if (hitStart && epiQ != EPI_MAX) epiQ <= epiQ + 1'b1;
        if (hitEnd) cycQ <= cycSum[CYC_W] ? CYC_MAX : cycSum[CYC_W-1:0];
      end
    end

    assign episodeFlat[g*EPI_W +: EPI_W] = epiQ;
    assign cyclesFlat[g*CYC_W +: CYC_W]  = cycQ;
  end
endmodule

// File: rtl/access_stall_ctrl.sv
module access_stall_ctrl
  import access_stall_pkg::*;
#(
  parameter int EPI_W = 16,
  parameter int CYC_W = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         setValid,
  input  logic [CAUSE_IDX_W-1:0]       setCause,
  input  logic                         clrValid,
  input  logic [CAUSE_IDX_W-1:0]       clrCause,
  input  logic                         reqValid,
  output logic                         portBlocked,
  output logic                         retryPulse,
  output logic [CAUSE_COUNT*EPI_W-1:0] episodeFlat,
  output logic [CAUSE_COUNT*CYC_W-1:0] cyclesFlat
);
  stat_strobe_t strobe;

  access_stall_control u_control (
    .clk(clk), .rstN(rstN),
    .setValid(setValid), .setCause(setCause),
    .clrValid(clrValid), .clrCause(clrCause),
    .reqValid(reqValid),
    .portBlocked(portBlocked), .retryPulse(retryPulse),
    .strobe(strobe)
  );

  access_stall_datapath #(.EPI_W(EPI_W), .CYC_W(CYC_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .episodeFlat(episodeFlat), .cyclesFlat(cyclesFlat)
  );
endmodule

// File: rtl/access_stall_checker.sv
module access_stall_checker
  import access_stall_pkg::*;
#(
  parameter int EPI_W = 16,
  parameter int CYC_W = 32
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         portBlocked,
  input logic                         retryPulse,
  input logic [CAUSE_COUNT*EPI_W-1:0] episodeFlat,
  input logic [CAUSE_COUNT*CYC_W-1:0] cyclesFlat
);
  a_r7_retry_single: assert property (@(posedge clk) disable iff (!rstN)
    retryPulse |=> !retryPulse);

  a_r7_retry_port_open: assert property (@(posedge clk) disable iff (!rstN)
    retryPulse |-> !$past(portBlocked));

  a_r3_count_only_on_start: assert property (@(posedge clk) disable iff (!rstN)
    !portBlocked |-> $stable(episodeFlat));

  a_r4_no_count_while_held: assert property (@(posedge clk) disable iff (!rstN)
    (portBlocked && $past(portBlocked)) |-> $stable(episodeFlat));

  a_r5_charge_only_on_open: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(portBlocked) |-> $stable(cyclesFlat));

  for (genvar g = 0; g < CAUSE_COUNT; g++) begin : g_mono
    a_r8_episode_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
      episodeFlat[g*EPI_W +: EPI_W] >= $past(episodeFlat[g*EPI_W +: EPI_W]));
    a_r9_cycles_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
      cyclesFlat[g*CYC_W +: CYC_W] >= $past(cyclesFlat[g*CYC_W +: CYC_W]));
  end
endmodule

bind access_stall_ctrl access_stall_checker #(.EPI_W(EPI_W), .CYC_W(CYC_W)) u_checker (
  .clk(clk), .rstN(rstN), .portBlocked(portBlocked), .retryPulse(retryPulse),
  .episodeFlat(episodeFlat), .cyclesFlat(cyclesFlat)
);

// File: tb/access_stall_ctrl_bench.sv
module access_stall_ctrl_bench;
  localparam int EPI_W   = 4;
  localparam int CYC_W   = 6;
  localparam int NC      = 4;
  localparam int EPI_MAX = (1 << EPI_W) - 1;
  localparam int CYC_MAX = (1 << CYC_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic setValid = 1'b0, clrValid = 1'b0, reqValid = 1'b0;
  logic [1:0] setCause = '0, clrCause = '0;
  logic portBlocked, retryPulse;
  logic [NC*EPI_W-1:0] episodeFlat;
  logic [NC*CYC_W-1:0] cyclesFlat;

  always #2 clk = ~clk;

  access_stall_ctrl #(.EPI_W(EPI_W), .CYC_W(CYC_W)) u_access_stall_ctrl (
    .clk(clk), .rstN(rstN), .setValid(setValid), .setCause(setCause),
    .clrValid(clrValid), .clrCause(clrCause), .reqValid(reqValid),
    .portBlocked(portBlocked), .retryPulse(retryPulse),
    .episodeFlat(episodeFlat), .cyclesFlat(cyclesFlat)
  );

  typedef struct {
    int    due;
    string tag;
    bit    blk;
    bit    rty;
    int    epi[NC];
    int    cyc[NC];
  } exp_t;

  exp_t expQ[$];
  int nTests = 0;
  int nFail  = 0;
  int cyc    = 0;

  // model state, built from the requirements
  int mMask = 0;
  bit mPend = 1'b0;
  int mStart = 0;
  int mEpi[NC] = '{default: 0};
  int mCyc[NC] = '{default: 0};

  task automatic chk(string tag, string what, int act, int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, pushes the expected outputs after the edge
  task automatic op(string tag, bit sv, int sc, bit cv, int cc, bit rq);
    exp_t e;
    int nm;
    bit blkNow;
    @(negedge clk);
    setValid = sv; setCause = 2'(sc);
    clrValid = cv; clrCause = 2'(cc);
    reqValid = rq;
    blkNow = (mMask != 0);
    nm = mMask;
    if (cv) nm = nm & ~(1 << cc);
    if (sv) nm = nm | (1 << sc);
    if (mMask == 0 && nm != 0) begin
      if (mEpi[sc] < EPI_MAX) mEpi[sc]++;
      mStart = cyc + 1;
    end
    if (mMask != 0 && nm == 0) begin
      mCyc[cc] = mCyc[cc] + (cyc + 1 - mStart);
      if (mCyc[cc] > CYC_MAX) mCyc[cc] = CYC_MAX;
    end
    e.rty = mPend && !blkNow;
    if (e.rty) mPend = 1'b0;
    else if (rq && blkNow) mPend = 1'b1;
    mMask = nm;
    e.due = cyc + 1;
    e.tag = tag;
    e.blk = (nm != 0);
    e.epi = mEpi;
    e.cyc = mCyc;
    expQ.push_back(e);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) op(tag, 0, 0, 0, 0, 0);
  endtask

  // monitor: compares each expected item in the cycle it falls due
  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      while (expQ.size() > 0 && expQ[0].due == cyc) begin
        exp_t e;
        e = expQ.pop_front();
        chk(e.tag, "portBlocked", int'(portBlocked), int'(e.blk));
        chk(e.tag, "retryPulse", int'(retryPulse), int'(e.rty));
        for (int k = 0; k < NC; k++) begin
          chk(e.tag, $sformatf("episode[%0d]", k), int'(episodeFlat[k*EPI_W +: EPI_W]), e.epi[k]);
          chk(e.tag, $sformatf("cycles[%0d]", k), int'(cyclesFlat[k*CYC_W +: CYC_W]), e.cyc[k]);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "portBlocked", int'(portBlocked), 0);
    chk("R1", "retryPulse", int'(retryPulse), 0);
    chk("R1", "episodes", int'(episodeFlat != '0), 0);
    chk("R1", "cycles", int'(cyclesFlat != '0), 0);
    rstN = 1'b1;

    // R3 / R5: a single episode of four cycles on cause 0
    op("R3", 1, 0, 0, 0, 0);
    idle("R5", 3);
    op("R5", 0, 0, 1, 0, 0);

    // R2 / R4: overlapping causes, clear of an unset cause
    op("R2", 1, 1, 0, 0, 0);
    op("R4", 1, 3, 0, 0, 0);
    op("R2", 0, 0, 1, 1, 0);
    op("R2", 0, 0, 1, 2, 0);
    idle("R2", 2);
    op("R5", 0, 0, 1, 3, 0);
    op("R2", 0, 0, 1, 0, 0);

    // R6: set and clear of the same cause in one cycle
    op("R6", 1, 2, 1, 2, 0);
    op("R6", 1, 2, 1, 2, 0);
    op("R6", 0, 0, 1, 2, 0);

    // R7: retry after a turned-away request, none for an open-port request
    op("R7", 1, 0, 0, 0, 0);
    op("R7", 0, 0, 0, 0, 1);
    op("R7", 0, 0, 1, 0, 1);
    idle("R7", 3);
    op("R7", 0, 0, 0, 0, 1);
    idle("R7", 3);

    // R8: episode counter saturation
    for (int i = 0; i < 20; i++) begin
      op("R8", 1, 1, 0, 0, 0);
      op("R8", 0, 0, 1, 1, 0);
    end

    // R9: cycle counter saturation, then a further episode
    op("R9", 1, 3, 0, 0, 0);
    idle("R9", 70);
    op("R9", 0, 0, 1, 3, 0);
    op("R9", 1, 3, 0, 0, 0);
    idle("R9", 5);
    op("R9", 0, 0, 1, 3, 0);
    idle("R9", 2);

    repeat (3) @(posedge clk);
    #2;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule